// File: doc/BRIEF.md
# Key-Locked Memory Controller Configuration Register File

This block is the software-visible configuration space of a DRAM controller. It is reached over a plain 32-bit word bus: a byte address, a write strobe, write data, and read data that follows the address in the same cycle. The window covers 4 KB. The low two address bits are ignored and the rest form a word index. A parameterised number of 32-bit registers is implemented, eight by default. Reads beyond the last register return zero, and writes beyond it are discarded.

Word 0 is a protection key. Software can always write it. Writes to every other word take effect only while the key word holds 0xFC600309. Word 1 (byte offset 0x04) is the configuration word. Some of its bits are read-only and keep their value whatever software writes. Which bits are read-only, and the value the word takes at reset, depend on a generation parameter (older or newer). The reset value also depends on a DRAM-size parameter, which is encoded into a 2-bit size code. A one-cycle error pulse reports each discarded write.

Top module: `memctl_cfg_regs`

## Requirements
- R1: After reset every register reads zero except the configuration word at byte offset 0x04. For the older generation that word resets to 0x40 with the size code in bits 1:0. For the newer generation it resets to 0x1000000C with the size code in bits 1:0.
- R2: A write to byte offset 0x00 is always accepted, and the key word then reads back exactly the written value.
- R3: While the key word differs from 0xFC600309, a write to any other in-range offset changes no register.
- R4: While the key word equals 0xFC600309, a write to an in-range offset at or above 0x08 stores the full 32-bit value, which then reads back unchanged.
- R5: For the older generation, an accepted write to offset 0x04 leaves bits 31:11, bit 6 and bits 3:2 unchanged and replaces all other bits with the written data.
- R6: For the newer generation, an accepted write to offset 0x04 leaves bits 31:28, bits 19:14, bit 6 and bits 3:2 unchanged and replaces all other bits with the written data.
- R7: For the older generation the size code is 0 for 64 MB, 1 for 128 MB, 2 for 256 MB and 3 for 512 MB. Any other size gives code 2.
- R8: For the newer generation the size code is 0 for 128 MB, 1 for 256 MB, 2 for 512 MB and 3 for 1024 MB. Any other size gives code 2.
- R9: An address whose word index is at or above the register count reads as zero. A write to such an address changes no register.
- R10: `wr_err` is high for exactly the cycle after a write is discarded, whether the write was dropped by the lock (R3) or by the range check (R9). It is low in the cycle after any cycle with no write or with an accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W (12) | Byte address; bits 1:0 ignored |
| bus_wen | input | 1 | Write strobe for one 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wr_err | output | 1 | One-cycle pulse after a discarded write |

## Verification
The assertions check on every cycle the lock and range rules that hold for any input:
- a key write lands as written;
- a write that is locked or out of range leaves the whole register array unchanged;
- the protected bits of the configuration word never change on a write;
- an out-of-range read returns zero;
- the error output follows discarded writes.

Only the bench scenarios can show the absolute values:
- the generation- and size-dependent reset words, including the fallback codes;
- the exact merge of written data into the configuration word for each generation;
- plain storage of the spare registers once the block is unlocked.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;

  typedef enum logic {
    GEN_OLD = 1'b0,
    GEN_NEW = 1'b1
  } gen_e;

  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] UNLOCK_KEY  = 32'hFC60_0309;
  localparam logic [WORD_W-1:0] RO_MASK_OLD = 32'hFFFF_F84C;
  localparam logic [WORD_W-1:0] RO_MASK_NEW = 32'hF00F_C04C;
  localparam logic [WORD_W-1:0] RST_BASE_OLD = 32'h0000_0040;
  localparam logic [WORD_W-1:0] RST_BASE_NEW = 32'h1000_000C;

  function automatic logic [1:0] size_code_old(int unsigned mb);
    case (mb)
      64:      return 2'd0;
      128:     return 2'd1;
      256:     return 2'd2;
      512:     return 2'd3;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [1:0] size_code_new(int unsigned mb);
    case (mb)
      128:     return 2'd0;
      256:     return 2'd1;
      512:     return 2'd2;
      1024:    return 2'd3;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/memctl_cfg_rstval.sv
module memctl_cfg_rstval
  import memctl_cfg_pkg::*;
#(
  parameter gen_e        GEN     = GEN_OLD,
  parameter int unsigned DRAM_MB = 256
) (
  output logic [WORD_W-1:0] conf_rst,
  output logic [WORD_W-1:0] ro_mask
);

  generate
    if (GEN == GEN_OLD) begin : g_old
      localparam logic [1:0] CODE = size_code_old(DRAM_MB);
      assign conf_rst = RST_BASE_OLD | {{(WORD_W-2){1'b0}}, CODE};
      assign ro_mask  = RO_MASK_OLD;
    end else begin : g_new
      localparam logic [1:0] CODE = size_code_new(DRAM_MB);
      assign conf_rst = RST_BASE_NEW | {{(WORD_W-2){1'b0}}, CODE};
      assign ro_mask  = RO_MASK_NEW;
    end
  endgenerate

endmodule

// File: rtl/memctl_cfg_decode.sv
module memctl_cfg_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wen,
  input  logic                unlocked,
  output logic [IDX_W-1:0]    idx,
  output logic                in_range,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic                wr_drop
);

  logic [1:0] unused_lo;

  assign unused_lo = addr[1:0];
  assign idx       = addr[ADDR_W-1:2];
  assign in_range  = (idx < IDX_W'(NUM_REGS));

  // Word 0 (key) ignores the lock; all others need it.
  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      if (i == 0) begin : g_key
        assign wr_sel[i] = wen && (idx == IDX_W'(i));
      end else begin : g_prot
        assign wr_sel[i] = wen && unlocked && (idx == IDX_W'(i));
      end
    end
  endgenerate

  assign wr_drop = wen && (!in_range || ((idx != '0) && !unlocked));

endmodule

// File: rtl/memctl_cfg_regbank.sv
module memctl_cfg_regbank
  import memctl_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned CONF_IDX = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0]              wr_sel,
  input  logic [WORD_W-1:0]                wdata,
  input  logic [WORD_W-1:0]                conf_rst,
  input  logic [WORD_W-1:0]                ro_mask,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_q
);

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [WORD_W-1:0] val_q;
      logic [WORD_W-1:0] val_d;
      logic [WORD_W-1:0] rst_val;

      if (i == CONF_IDX) begin : g_conf
        assign rst_val = conf_rst;
        always_comb begin
          val_d = (val_q & ro_mask) | (wdata & ~ro_mask);
        end
      end else begin : g_plain
        assign rst_val = '0;
        always_comb begin
          val_d = wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= rst_val;
        end else if (wr_sel[i]) begin
          val_q <= val_d;
        end
      end

      assign regs_q[i] = val_q;
    end
  endgenerate

endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
  import memctl_cfg_pkg::*;
#(
  parameter gen_e        GEN      = GEN_OLD,
  parameter int unsigned DRAM_MB  = 512,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wr_err
);

  localparam int unsigned IDX_W    = ADDR_W - 2;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);
  localparam int unsigned CONF_IDX = 1;

  logic [1:0]                        rst_pipe_q;
  logic                              rst_sync_n;
  logic [WORD_W-1:0]                 conf_rst;
  logic [WORD_W-1:0]                 ro_mask;
  logic [IDX_W-1:0]                  idx;
  logic                              in_range;
  logic [NUM_REGS-1:0]               wr_sel;
  logic                              wr_drop;
  logic                              unlocked;
  logic [NUM_REGS-1:0][WORD_W-1:0]   regs_q;
  logic                              wr_err_d;
  logic                              wr_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  memctl_cfg_rstval #(
    .GEN     (GEN),
    .DRAM_MB (DRAM_MB)
  ) u_rstval (
    .conf_rst (conf_rst),
    .ro_mask  (ro_mask)
  );

  assign unlocked = (regs_q[0] == UNLOCK_KEY);

  memctl_cfg_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_decode (
    .addr     (bus_addr),
    .wen      (bus_wen),
    .unlocked (unlocked),
    .idx      (idx),
    .in_range (in_range),
    .wr_sel   (wr_sel),
    .wr_drop  (wr_drop)
  );

  memctl_cfg_regbank #(
    .NUM_REGS (NUM_REGS),
    .CONF_IDX (CONF_IDX)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_sel   (wr_sel),
    .wdata    (bus_wdata),
    .conf_rst (conf_rst),
    .ro_mask  (ro_mask),
    .regs_q   (regs_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (in_range) begin
      bus_rdata = regs_q[idx[SEL_W-1:0]];
    end
  end

  always_comb begin
    wr_err_d = wr_drop;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_err_q <= 1'b0;
    end else begin
      wr_err_q <= wr_err_d;
    end
  end

  assign wr_err = wr_err_q;

endmodule

// File: rtl/memctl_cfg_regs_chk.sv
module memctl_cfg_regs_chk
  import memctl_cfg_pkg::*;
#(
  parameter gen_e        GEN      = GEN_OLD,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic                            bus_wen,
  input logic [31:0]                     bus_wdata,
  input logic [31:0]                     bus_rdata,
  input logic                            wr_err,
  input logic [NUM_REGS-1:0][WORD_W-1:0] regs_q
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] ROM = (GEN == GEN_OLD) ? RO_MASK_OLD : RO_MASK_NEW;

  logic [IDX_W-1:0] cidx;
  logic [1:0]       unused_lo;
  logic             oor;
  logic             locked;

  assign cidx      = bus_addr[ADDR_W-1:2];
  assign unused_lo = bus_addr[1:0];
  assign oor       = (cidx >= IDX_W'(NUM_REGS));
  assign locked    = (regs_q[0] != UNLOCK_KEY);

  p_key_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && cidx == '0) |=> (regs_q[0] == $past(bus_wdata)));

  p_locked_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && !oor && cidx != '0 && locked) |=> (regs_q == $past(regs_q)));

  // Covers R5 (older generation) and R6 (newer generation).
  p_ro_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && cidx == IDX_W'(1)) |=> (((regs_q[1] ^ $past(regs_q[1])) & ROM) == '0));

  p_oor_rdzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> (bus_rdata == '0));

  p_oor_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && oor) |=> (regs_q == $past(regs_q)));

  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && (oor || (cidx != '0 && locked))) |=> wr_err);

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wen) |=> !wr_err);

endmodule

bind memctl_cfg_regs memctl_cfg_regs_chk #(
  .GEN      (GEN),
  .NUM_REGS (NUM_REGS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .wr_err    (wr_err),
  .regs_q    (regs_q)
);

// File: tb/memctl_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module memctl_cfg_regs_tb_top;
  import memctl_cfg_pkg::*;

  localparam logic [31:0] KEY    = 32'hFC60_0309;
  localparam logic [31:0] BM_OLD = 32'hFFFF_F84C;
  localparam logic [31:0] BM_NEW = 32'hF00F_C04C;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wen = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1, rd2, rd3;
  logic        err0, err1, err2, err3;

  item_t       q[$];
  logic [31:0] m0[8];
  logic [31:0] m1[8];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  memctl_cfg_regs #(.GEN(GEN_OLD), .DRAM_MB(512)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen),
    .bus_wdata(wdata), .bus_rdata(rd0), .wr_err(err0));
  memctl_cfg_regs #(.GEN(GEN_NEW), .DRAM_MB(1024)) dut_new (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen),
    .bus_wdata(wdata), .bus_rdata(rd1), .wr_err(err1));
  memctl_cfg_regs #(.GEN(GEN_OLD), .DRAM_MB(100)) dut_ofb (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen),
    .bus_wdata(wdata), .bus_rdata(rd2), .wr_err(err2));
  memctl_cfg_regs #(.GEN(GEN_NEW), .DRAM_MB(100)) dut_nfb (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen),
    .bus_wdata(wdata), .bus_rdata(rd3), .wr_err(err3));

  function automatic void push(int sel, logic [31:0] exp, string req);
    item_t it;
    it.sel = sel;
    it.exp = exp;
    it.req = req;
    q.push_back(it);
  endfunction

  function automatic logic [31:0] actual(int sel);
    case (sel)
      0:       return rd0;
      1:       return rd1;
      2:       return rd2;
      3:       return rd3;
      default: return {31'b0, err0};
    endcase
  endfunction

  // Monitor: compares every queued expectation away from the clock edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = actual(it.sel);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=0x%08h expected=0x%08h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    int ix;
    bit drop;
    ix = int'(a >> 2);
    @(posedge clk); #1;
    addr = a; wen = 1'b1; wdata = d;
    drop = (ix >= 8) || (ix != 0 && m0[0] != KEY);
    if (!drop) begin
      if (ix == 1) begin
        m0[1] = (m0[1] & BM_OLD) | (d & ~BM_OLD);
        m1[1] = (m1[1] & BM_NEW) | (d & ~BM_NEW);
      end else begin
        m0[ix] = d;
        m1[ix] = d;
      end
    end
    @(posedge clk); #1;
    wen = 1'b0;
    push(4, {31'b0, drop}, {req, " R10"});
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    int ix;
    ix = int'(a >> 2);
    @(posedge clk); #1;
    addr = a; wen = 1'b0;
    push(0, (ix < 8) ? m0[ix] : 32'h0, req);
    push(1, (ix < 8) ? m1[ix] : 32'h0, req);
    push(4, 32'h0, "R10 quiet");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m0[i] = '0;
      m1[i] = '0;
    end
    m0[1] = 32'h0000_0043;  // R1 R7: older, 512 MB -> code 3
    m1[1] = 32'h1000_000F;  // R1 R8: newer, 1024 MB -> code 3

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 R7 R8: reset values and size-code fallback
    rd(12'h004, "R1 R7 R8 conf reset");
    push(2, 32'h0000_0042, "R7 fallback older");
    push(3, 32'h1000_000E, "R8 fallback newer");
    rd(12'h000, "R1 key reset");
    rd(12'h014, "R1 spare reset");

    // R3: locked writes are dropped
    wr(12'h004, 32'hFFFF_FFFF, "R3 locked conf");
    rd(12'h004, "R3 conf held");
    wr(12'h014, 32'h1111_2222, "R3 locked spare");
    rd(12'h014, "R3 spare held");

    // R2: key register always writable
    wr(12'h000, 32'h1234_5678, "R2 wrong key");
    rd(12'h000, "R2 key readback");
    wr(12'h014, 32'h3333_4444, "R3 still locked");
    rd(12'h014, "R3 spare held 2");

    // R4: unlocked storage
    wr(12'h000, KEY, "R2 unlock");
    rd(12'h000, "R2 key readback 2");
    wr(12'h014, 32'hA5A5_5A5A, "R4 spare5");
    rd(12'h014, "R4 spare5 readback");
    wr(12'h01C, 32'h0BAD_F00D, "R4 last reg");
    rd(12'h01C, "R4 last reg readback");

    // R5 R6: read-only field preservation
    wr(12'h004, 32'hFFFF_FFFF, "R5 R6 conf ones");
    rd(12'h004, "R5 R6 conf after ones");
    wr(12'h004, 32'h0000_0000, "R5 R6 conf zeros");
    rd(12'h004, "R5 R6 conf after zeros");
    wr(12'h005, 32'h5A5A_A5A5, "R5 R6 low addr bits");
    rd(12'h004, "R5 R6 conf pattern");

    // R9: out of range
    wr(12'h020, 32'hDEAD_BEEF, "R9 oor write");
    rd(12'h020, "R9 oor read");
    rd(12'hFFC, "R9 top of window");
    for (int i = 0; i < 8; i++) rd(12'(i * 4), "R9 regs untouched");

    // R3 R10: relock, then drop
    wr(12'h000, 32'h0, "R2 relock");
    wr(12'h014, 32'h0000_0077, "R3 relocked write");
    rd(12'h014, "R3 relocked spare held");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule